// File: doc/BRIEF.md
# RTS/CTS Automatic Flow Controller

This block performs automatic hardware handshaking for a single UART channel. On the receive side it watches the fill level of the receive FIFO and drives an active-low request-to-send line. It uses two separate thresholds, one to stop the far end and one to let it resume, so the line does not chatter. On the transmit side it synchronizes the active-low clear-to-send input and tells the serializer whether it may begin its next character. It also raises a sticky flag whenever either handshake line moves from active to inactive.

Each threshold is a 4-bit code multiplied by four, which gives FIFO levels from 0 to 60 on a 64-entry FIFO. The clear-to-send decision is frozen while a character is on the wire. It is taken again at the middle of that character's last stop bit, so a byte already started always completes. The FIFO, the serializer and any register access sit outside this block. All pins are plain control and status signals. There is no data stream and no valid/ready back-pressure.

Top module: `uart_autoflow_ctl`

## Requirements
- R1: While reset is held and right after it is released, `rts_n` is 1 and `flow_irq` is 0. With `auto_cts_en` = 0, `tx_start_allowed` is 1.
- R2: With `auto_rts_en` = 0, `rts_n` equals the inverse of `rts_manual` one clock after the inputs are presented. Writing 1 drives the line low.
- R3: With `auto_rts_en` = 1 and RTS currently asserted, `rts_n` stays 0 while `rx_level` is below `halt_code`×4.
- R4: With `auto_rts_en` = 1, `rts_n` goes to 1 one clock after `rx_level` reaches `halt_code`×4. It stays 1 as the level rises further, so the one extra byte the sender may still deliver is accepted.
- R5: Once deasserted by the halt threshold, `rts_n` stays 1 until `rx_level` falls to `resume_code`×4 or below. It then returns to 0 one clock later. This assumes `resume_code` < `halt_code`.
- R6: With `auto_cts_en` = 0, `tx_start_allowed` is 1 whatever `cts_n` does.
- R7: With `auto_cts_en` = 1 and no character in flight, `tx_start_allowed` equals the inverse of `cts_n` three clocks after `cts_n` changes: two synchronizer stages plus one register. When `cts_n` returns from high to low, transmission may start again.
- R8: With `auto_cts_en` = 1, `tx_start_allowed` holds its value from `tx_char_start` until `tx_stop_mid`. On the clock of `tx_stop_mid` it takes the synchronized CTS state, so CTS going inactive before mid-stop blocks the next character but not the current one.
- R9: `flow_irq` is set when `rts_n` goes from 0 to 1 or when the synchronized `cts_n` goes from 0 to 1. An inactive-to-active change of either line does not set it.
- R10: A pulse on `flow_irq_ack` clears `flow_irq` on the next clock. A new change on the same clock wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_level | input | LVL_W (7) | Receive FIFO fill level, 0 to DEPTH |
| halt_code | input | THR_W (4) | Halt threshold code, level = code×4 |
| resume_code | input | THR_W (4) | Resume threshold code, level = code×4 |
| auto_rts_en | input | 1 | 1 = RTS driven from FIFO level |
| auto_cts_en | input | 1 | 1 = CTS gates the transmitter |
| rts_manual | input | 1 | Manual RTS bit, 1 drives `rts_n` low |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| tx_char_start | input | 1 | Pulse: serializer begins a character |
| tx_stop_mid | input | 1 | Pulse: middle of the last stop bit |
| flow_irq_ack | input | 1 | Pulse: clear the change flag |
| rts_n | output | 1 | Request-to-send, active low, registered |
| tx_start_allowed | output | 1 | 1 = next character may be started |
| flow_irq | output | 1 | Sticky active-to-inactive change flag |

## Verification
On every clock, assertions check that a level at or above halt forces `rts_n` high on the next cycle. They check that a level at or below resume, under halt, releases it. They also check that manual mode mirrors the control bit, that the transmit permission holds steady through a character and latches CTS at mid-stop, and that each inactive-going edge sets the flag. The hysteresis band (levels between the two thresholds that keep whichever state came first) and the exact three-cycle CTS latency can only be shown by the bench's ordered scenarios. The same applies to the case where CTS glitches and recovers inside a character, and to a flag that stays clear on active-going edges.

// File: rtl/autoflow_pkg.sv
package autoflow_pkg;
  localparam int DEF_DEPTH    = 64;
  localparam int DEF_THR_W    = 4;
  localparam int DEF_SCALE_SH = 2;
  localparam int DEF_SYNC     = 2;

  function automatic int lvl_width(input int depth);
    return $clog2(depth) + 1;
  endfunction
endpackage

// File: rtl/rts_level_ctl.sv
module rts_level_ctl #(
  parameter int LVL_W    = 7,
  parameter int THR_W    = 4,
  parameter int SCALE_SH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [THR_W-1:0] halt_code,
  input  logic [THR_W-1:0] resume_code,
  input  logic             auto_en,
  input  logic             manual,
  output logic             rts_n
);
  logic [LVL_W-1:0] halt_lvl, resume_lvl;
  logic             stop_q, stop_d, rts_q;

  assign halt_lvl   = LVL_W'(halt_code) << SCALE_SH;
  assign resume_lvl = LVL_W'(resume_code) << SCALE_SH;

  // hysteresis: enter stop at halt, leave only at or below resume
  always_comb begin
    if (!auto_en)    stop_d = 1'b0;
    else if (stop_q) stop_d = (rx_level > resume_lvl);
    else             stop_d = (rx_level >= halt_lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      rts_q  <= 1'b1;
    end else begin
      stop_q <= stop_d;
      rts_q  <= auto_en ? stop_d : ~manual;
    end
  end

  assign rts_n = rts_q;

  // R4
  rts_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && rx_level >= halt_lvl && halt_lvl > resume_lvl) |=> rts_n);
  // R5
  rts_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && rx_level <= resume_lvl && rx_level < halt_lvl) |=> !rts_n);
  // R2
  rts_manual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> (rts_n == !$past(manual)));
endmodule

// File: rtl/cts_tx_gate.sv
module cts_tx_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n,
  input  logic auto_en,
  input  logic char_start,
  input  logic stop_mid,
  output logic start_ok,
  output logic cts_n_sync
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   in_char_q, permit_q, cts_ok;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[0] <= 1'b1;
          else        sync_q[0] <= cts_n;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[s] <= 1'b1;
          else        sync_q[s] <= sync_q[s-1];
      end
    end
  endgenerate

  assign cts_n_sync = sync_q[SYNC_STAGES-1];
  assign cts_ok     = ~cts_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_char_q <= 1'b0;
      permit_q  <= 1'b0;
    end else begin
      if (stop_mid)        in_char_q <= 1'b0;
      else if (char_start) in_char_q <= 1'b1;

      if (stop_mid)                       permit_q <= cts_ok;
      else if (!in_char_q && !char_start) permit_q <= cts_ok;
    end
  end

  assign start_ok = !auto_en || permit_q;

  // R8
  cts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_char_q && !stop_mid) |=> $stable(permit_q));
  // R8
  cts_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_mid |=> (permit_q == !$past(cts_n_sync)));
  // R6
  cts_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |-> start_ok);
endmodule

// File: rtl/flow_change_irq.sv
module flow_change_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic rts_n,
  input  logic cts_n_sync,
  input  logic ack,
  output logic irq
);
  logic rts_prev_q, cts_prev_q, irq_q, rise;

  assign rise = (rts_n & ~rts_prev_q) | (cts_n_sync & ~cts_prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rts_prev_q <= 1'b1;
      cts_prev_q <= 1'b1;
      irq_q      <= 1'b0;
    end else begin
      rts_prev_q <= rts_n;
      cts_prev_q <= cts_n_sync;
      if (rise)     irq_q <= 1'b1;
      else if (ack) irq_q <= 1'b0;
    end
  end

  assign irq = irq_q;

  // R9
  irq_cts_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cts_n_sync) |=> irq);
  // R10
  irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !rise) |=> !irq);
endmodule

// File: rtl/uart_autoflow_ctl.sv
module uart_autoflow_ctl
  import autoflow_pkg::*;
#(
  parameter int DEPTH       = DEF_DEPTH,
  parameter int THR_W       = DEF_THR_W,
  parameter int SCALE_SH    = DEF_SCALE_SH,
  parameter int SYNC_STAGES = DEF_SYNC,
  localparam int LVL_W      = lvl_width(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [THR_W-1:0] halt_code,
  input  logic [THR_W-1:0] resume_code,
  input  logic             auto_rts_en,
  input  logic             auto_cts_en,
  input  logic             rts_manual,
  input  logic             cts_n,
  input  logic             tx_char_start,
  input  logic             tx_stop_mid,
  input  logic             flow_irq_ack,
  output logic             rts_n,
  output logic             tx_start_allowed,
  output logic             flow_irq
);
  logic cts_n_sync;

  rts_level_ctl #(.LVL_W(LVL_W), .THR_W(THR_W), .SCALE_SH(SCALE_SH)) u_rts (
    .clk, .rst_n, .rx_level, .halt_code, .resume_code,
    .auto_en(auto_rts_en), .manual(rts_manual), .rts_n
  );

  cts_tx_gate #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
    .clk, .rst_n, .cts_n, .auto_en(auto_cts_en),
    .char_start(tx_char_start), .stop_mid(tx_stop_mid),
    .start_ok(tx_start_allowed), .cts_n_sync
  );

  flow_change_irq u_irq (
    .clk, .rst_n, .rts_n, .cts_n_sync, .ack(flow_irq_ack), .irq(flow_irq)
  );

  // R9
  irq_rts_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts_n) |=> flow_irq);
endmodule

// File: tb/uart_autoflow_ctl_tb.sv
`timescale 1ns/1ps
module uart_autoflow_ctl_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic [6:0] rx_level;
  logic [3:0] halt_code, resume_code;
  logic auto_rts_en, auto_cts_en, rts_manual, cts_n;
  logic tx_char_start, tx_stop_mid, flow_irq_ack;
  logic rts_n, tx_start_allowed, flow_irq;
  int n_vec = 0, n_bad = 0;

  always #2 clk = ~clk;

  uart_autoflow_ctl u_dut (
    .clk, .rst_n, .rx_level, .halt_code, .resume_code, .auto_rts_en,
    .auto_cts_en, .rts_manual, .cts_n, .tx_char_start, .tx_stop_mid,
    .flow_irq_ack, .rts_n, .tx_start_allowed, .flow_irq
  );

  // {level, halt, resume, auto_rts, manual, expected rts_n}
  localparam logic [17:0] VEC [14] = '{
    {7'd0,  4'd15, 4'd8, 1'b0, 1'b0, 1'b1},  // R2 manual off
    {7'd0,  4'd15, 4'd8, 1'b0, 1'b1, 1'b0},  // R2 manual on
    {7'd10, 4'd15, 4'd8, 1'b1, 1'b0, 1'b0},  // R3
    {7'd59, 4'd15, 4'd8, 1'b1, 1'b0, 1'b0},  // R3 just under halt
    {7'd60, 4'd15, 4'd8, 1'b1, 1'b0, 1'b1},  // R4 reach halt
    {7'd61, 4'd15, 4'd8, 1'b1, 1'b0, 1'b1},  // R4 extra byte
    {7'd40, 4'd15, 4'd8, 1'b1, 1'b0, 1'b1},  // R5 band
    {7'd33, 4'd15, 4'd8, 1'b1, 1'b0, 1'b1},  // R5 just above resume
    {7'd32, 4'd15, 4'd8, 1'b1, 1'b0, 1'b0},  // R5 resume
    {7'd45, 4'd15, 4'd8, 1'b1, 1'b0, 1'b0},  // R3 band from below
    {7'd45, 4'd10, 4'd8, 1'b1, 1'b0, 1'b1},  // R4 lowered halt
    {7'd20, 4'd10, 4'd2, 1'b1, 1'b0, 1'b1},  // R5 new resume
    {7'd8,  4'd10, 4'd2, 1'b1, 1'b0, 1'b0},  // R5 at new resume
    {7'd63, 4'd10, 4'd2, 1'b0, 1'b0, 1'b1}   // R2 back to manual
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_ack();
    flow_irq_ack = 1'b1; tick(1); flow_irq_ack = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_level = '0; halt_code = 4'd15; resume_code = 4'd8;
    auto_rts_en = 0; auto_cts_en = 0; rts_manual = 0; cts_n = 1;
    tx_char_start = 0; tx_stop_mid = 0; flow_irq_ack = 0;
    tick(3);
    check("R1 rts_n in reset", rts_n, 1'b1);
    check("R1 irq in reset", flow_irq, 1'b0);
    check("R1 allowed in reset", tx_start_allowed, 1'b1);
    rst_n = 1'b1;
    tick(1);
    check("R1 rts_n after reset", rts_n, 1'b1);
    check("R1 irq after reset", flow_irq, 1'b0);

    for (int i = 0; i < 14; i++) begin
      {rx_level, halt_code, resume_code, auto_rts_en, rts_manual} = VEC[i][17:1];
      tick(1);
      check($sformatf("R2-5 vector %0d rts_n", i), rts_n, VEC[i][0]);
    end

    // R6: bypass ignores CTS
    auto_cts_en = 0; cts_n = 1; tick(4);
    check("R6 allowed with cts high", tx_start_allowed, 1'b1);

    // R7: idle tracking with three-cycle latency
    auto_cts_en = 1; tick(4);
    check("R7 cts high blocks", tx_start_allowed, 1'b0);
    cts_n = 0; tick(2);
    check("R7 not yet after 2", tx_start_allowed, 1'b0);
    tick(1);
    check("R7 resumes after 3", tx_start_allowed, 1'b1);

    // R8: frozen during character, latched at mid stop
    tx_char_start = 1; tick(1); tx_char_start = 0;
    cts_n = 1; tick(4);
    check("R8 held during char", tx_start_allowed, 1'b1);
    tx_stop_mid = 1; tick(1); tx_stop_mid = 0;
    check("R8 latched inactive at stop", tx_start_allowed, 1'b0);
    cts_n = 0; tick(3);
    check("R7 resume on cts low", tx_start_allowed, 1'b1);
    tx_char_start = 1; tick(1); tx_char_start = 0;
    cts_n = 1; tick(3); cts_n = 0; tick(3);
    tx_stop_mid = 1; tick(1); tx_stop_mid = 0;
    check("R8 recovered before stop", tx_start_allowed, 1'b1);

    // R9/R10: change flag
    pulse_ack();
    check("R10 ack clears", flow_irq, 1'b0);
    auto_rts_en = 0; rts_manual = 1; tick(3);
    check("R9 rts active-going no irq", flow_irq, 1'b0);
    rts_manual = 0; tick(2);
    check("R9 rts inactive-going irq", flow_irq, 1'b1);
    pulse_ack();
    check("R10 ack clears rts flag", flow_irq, 1'b0);
    cts_n = 1; tick(3);
    check("R9 cts inactive-going irq", flow_irq, 1'b1);
    pulse_ack();
    cts_n = 0; tick(4);
    check("R9 cts active-going no irq", flow_irq, 1'b0);
    // R10: set wins over simultaneous ack
    cts_n = 1; tick(2);
    flow_irq_ack = 1'b1; tick(1); flow_irq_ack = 1'b0;
    check("R10 set wins over ack", flow_irq, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule